// File: doc/BRIEF.md
# Page-Load and Program Timer Controller

This block sits in front of a slow, byte-wide non-volatile array and turns a stream of single-byte writes into one page programming operation. The first accepted write opens a page. Later writes to the same page are gathered into a local page buffer, with one valid bit per byte. If no further write for that page arrives within a set number of clocks, the page closes. A programming timer then runs for a fixed number of clocks. After that, the buffered bytes are handed to the array in one masked commit. Only the bytes that were loaded carry a set mask bit.

Reads are served at all times. While no programming is in progress, a read returns the array byte at the requested address. Once programming has started, a read returns a status byte. Bit 7 of that byte is the inverse of bit 7 of the last loaded byte, and bit 6 flips on every status read. Software can poll either bit to learn when the operation has finished. After the commit, reads return true array data again.

Write requests, read requests, read responses and the commit all use valid/ready handshakes. A transfer happens on a rising clock edge where both valid and ready are high.

Back-pressure rules:
- Write ready is low from the moment programming starts until the commit is accepted.
- Read request ready is low while a response is held and not being taken.
- A response stays valid and unchanged until it is taken.
- The commit stays valid and unchanged until the array accepts it.

Top module: `page_prog_ctrl`

## Requirements
- R1: On the first accepted write while idle, the block captures address bits [12:6] as the page and bits [5:0] as the byte offset. `busy` is high from the next cycle.
- R2: Writes to the open page may arrive in any order. When one offset is written twice, the later byte is the one committed.
- R3: A write whose address bits [12:6] differ from the open page is accepted by handshake but discarded. It does not restart the load window.
- R4: Let the last accepted same-page write complete on edge e. A same-page write completing on edge e+WIN_CYCLES still joins the page. If none arrives by then, programming begins on that edge and `wr_ready` falls.
- R5: Programming lasts PROG_CYCLES cycles. Then `cmt_valid` rises with `cmt_page`, the page data, and a mask with bit i set only if offset i was loaded. Array bytes that were not loaded keep their value.
- R6: `cmt_valid` and its payload stay stable until `cmt_ready`. The cycle after the commit handshake, `busy` is low and `wr_ready` is high.
- R7: A read accepted during programming or while the commit is pending returns a status byte. Bit 7 is the complement of bit 7 of the last accepted same-page byte. Bits 5:0 equal that byte's bits 5:0.
- R8: In status bytes, bit 6 is 0 on the first status read after programming starts and inverts on each later status read.
- R9: A read accepted while idle or loading returns `arr_rdata` as sampled at acceptance, `arr_raddr` being `rd_addr`.
- R10: `wr_ready` is low during programming and while the commit is pending. A write offered then waits and is taken after the commit, opening a new page.
- R11: A read response is presented one cycle after acceptance and is held stable while `rsp_ready` is low. While it is held, `rd_ready` is low.
- R12: After reset, `busy`, `cmt_valid` and `rsp_valid` are low and `wr_ready` and `rd_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write byte |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | ADDR_W | Read byte address |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | DATA_W | Read response byte |
| arr_raddr | output | ADDR_W | Array read address |
| arr_rdata | input | DATA_W | Array read data (combinational) |
| cmt_valid | output | 1 | Page commit valid |
| cmt_ready | input | 1 | Page commit accepted by array |
| cmt_page | output | ADDR_W-OFF_W | Page being committed |
| cmt_data | output | 2^OFF_W x DATA_W | Page bytes, offset i at bits [8i+7:8i] |
| cmt_mask | output | 2^OFF_W | Per-byte write mask |
| busy | output | 1 | Load or programming in progress |

## Verification
The bench targets the exact window edge in both directions: a write on the last allowed edge must join the page, and one a cycle later must wait for the commit. A design with an off-by-one window would close too early or absorb a late byte. It also loads a foreign-page byte in the middle of a page. A design that compared the wrong address bits would commit that byte or let it extend the window. Status reads are checked for the inverted bit 7 and for the bit 6 sequence 0,1,0. A design that reset the toggle at the wrong time or toggled on array reads would break that sequence. Commit and response back-pressure are held for several cycles, which exposes payloads that change or handshakes that are lost while stalled.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_LOAD   = 2'd1,
    PS_PROG   = 2'd2,
    PS_COMMIT = 2'd3
  } ppc_state_e;
endpackage

// File: rtl/ppc_seq.sv
module ppc_seq
  import ppc_pkg::*;
#(
  parameter int WIN_CYCLES  = 100,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_fire,
  input  logic       page_hit,
  input  logic       cmt_ready,
  output ppc_state_e state,
  output logic       first_load,
  output logic       store,
  output logic       enter_prog
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);
  localparam int PRG_W = $clog2(PROG_CYCLES + 1);

  logic [WIN_W-1:0] win_cnt;
  logic [PRG_W-1:0] prog_cnt;

  // Accepted store: opening write, or a same-page write while loading.
  always_comb begin
    first_load = wr_fire && (state == PS_IDLE);
    store      = first_load || (wr_fire && (state == PS_LOAD) && page_hit);
    enter_prog = (state == PS_LOAD) && !store &&
                 (win_cnt == WIN_W'(WIN_CYCLES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PS_IDLE;
      win_cnt  <= '0;
      prog_cnt <= '0;
    end else begin
      unique case (state)
        PS_IDLE: begin
          if (first_load) begin
            state   <= PS_LOAD;
            win_cnt <= '0;
          end
        end
        PS_LOAD: begin
          if (store) begin
            win_cnt <= '0;
          end else if (enter_prog) begin
            state    <= PS_PROG;
            prog_cnt <= '0;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        PS_PROG: begin
          if (prog_cnt == PRG_W'(PROG_CYCLES - 1)) begin
            state <= PS_COMMIT;
          end else begin
            prog_cnt <= prog_cnt + 1'b1;
          end
        end
        PS_COMMIT: begin
          if (cmt_ready) state <= PS_IDLE;
        end
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ppc_page_buf.sv
module ppc_page_buf #(
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          first_load,
  input  logic                          store,
  input  logic [PAGE_W-1:0]             page_in,
  input  logic [OFF_W-1:0]              off_in,
  input  logic [DATA_W-1:0]             data_in,
  output logic [PAGE_W-1:0]             page_q,
  output logic [DATA_W-1:0]             last_q,
  output logic [(1<<OFF_W)*DATA_W-1:0]  data_flat,
  output logic [(1<<OFF_W)-1:0]         mask_q
);
  localparam int SLOTS = 1 << OFF_W;

  logic [DATA_W-1:0] slot_q [SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      last_q <= '0;
      mask_q <= '0;
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= '0;
    end else if (store) begin
      last_q <= data_in;
      if (first_load) page_q <= page_in;
      for (int i = 0; i < SLOTS; i++) begin
        if (off_in == OFF_W'(i)) begin
          slot_q[i] <= data_in;
          mask_q[i] <= 1'b1;
        end else if (first_load) begin
          mask_q[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_flat
    assign data_flat[g*DATA_W +: DATA_W] = slot_q[g];
  end
endmodule

// File: rtl/ppc_status.sv
module ppc_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic              in_prog,
  input  logic              enter_prog,
  input  logic [DATA_W-1:0] last_byte,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic              tog_q;
  logic              rd_fire;
  logic [DATA_W-1:0] status_byte;

  assign rd_ready    = !rsp_valid || rsp_ready;
  assign rd_fire     = rd_valid && rd_ready;
  assign status_byte = {~last_byte[DATA_W-1], tog_q, last_byte[DATA_W-3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      tog_q     <= 1'b0;
    end else begin
      if (rd_fire) begin
        rsp_valid <= 1'b1;
        rsp_data  <= in_prog ? status_byte : arr_rdata;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (enter_prog)           tog_q <= 1'b0;
      else if (rd_fire && in_prog) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl
  import ppc_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int OFF_W       = 6,
  parameter int DATA_W      = 8,
  parameter int WIN_CYCLES  = 100,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_valid,
  output logic                              wr_ready,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              rd_valid,
  output logic                              rd_ready,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [DATA_W-1:0]                 rsp_data,
  output logic [ADDR_W-1:0]                 arr_raddr,
  input  logic [DATA_W-1:0]                 arr_rdata,
  output logic                              cmt_valid,
  input  logic                              cmt_ready,
  output logic [ADDR_W-OFF_W-1:0]           cmt_page,
  output logic [(1<<OFF_W)*DATA_W-1:0]      cmt_data,
  output logic [(1<<OFF_W)-1:0]             cmt_mask,
  output logic                              busy
);
  localparam int PAGE_W = ADDR_W - OFF_W;

  ppc_state_e        state;
  logic              wr_fire, page_hit, first_load, store, enter_prog, in_prog;
  logic [PAGE_W-1:0] page_q;
  logic [DATA_W-1:0] last_q;

  assign wr_ready  = (state == PS_IDLE) || (state == PS_LOAD);
  assign wr_fire   = wr_valid && wr_ready;
  assign page_hit  = (wr_addr[ADDR_W-1:OFF_W] == page_q);
  assign in_prog   = (state == PS_PROG) || (state == PS_COMMIT);
  assign cmt_valid = (state == PS_COMMIT);
  assign cmt_page  = page_q;
  assign busy      = (state != PS_IDLE);
  assign arr_raddr = rd_addr;

  ppc_seq #(
    .WIN_CYCLES (WIN_CYCLES),
    .PROG_CYCLES(PROG_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .page_hit  (page_hit),
    .cmt_ready (cmt_ready),
    .state     (state),
    .first_load(first_load),
    .store     (store),
    .enter_prog(enter_prog)
  );

  ppc_page_buf #(
    .OFF_W (OFF_W),
    .DATA_W(DATA_W),
    .PAGE_W(PAGE_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .first_load(first_load),
    .store     (store),
    .page_in   (wr_addr[ADDR_W-1:OFF_W]),
    .off_in    (wr_addr[OFF_W-1:0]),
    .data_in   (wr_data),
    .page_q    (page_q),
    .last_q    (last_q),
    .data_flat (cmt_data),
    .mask_q    (cmt_mask)
  );

  ppc_status #(
    .DATA_W(DATA_W)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .in_prog   (in_prog),
    .enter_prog(enter_prog),
    .last_byte (last_q),
    .arr_rdata (arr_rdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/ppc_chk.sv
module ppc_chk #(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 6,
  parameter int DATA_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         wr_valid,
  input logic                         wr_ready,
  input logic                         rd_ready,
  input logic                         rsp_valid,
  input logic                         rsp_ready,
  input logic [DATA_W-1:0]            rsp_data,
  input logic                         cmt_valid,
  input logic                         cmt_ready,
  input logic [ADDR_W-OFF_W-1:0]      cmt_page,
  input logic [(1<<OFF_W)*DATA_W-1:0] cmt_data,
  input logic [(1<<OFF_W)-1:0]        cmt_mask,
  input logic                         busy
);
  // R10
  load_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> !wr_ready);
  // R6
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && !cmt_ready |=> cmt_valid && $stable(cmt_mask) &&
    $stable(cmt_page) && $stable(cmt_data));
  // R6
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && cmt_ready |=> !busy && wr_ready);
  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R11
  rsp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !rd_ready);
  // R1
  open_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && !busy |=> busy);
  // R5
  commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> cmt_mask != '0);
endmodule

bind page_prog_ctrl ppc_chk #(
  .ADDR_W(ADDR_W),
  .OFF_W (OFF_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .rd_ready (rd_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .cmt_valid(cmt_valid),
  .cmt_ready(cmt_ready),
  .cmt_page (cmt_page),
  .cmt_data (cmt_data),
  .cmt_mask (cmt_mask),
  .busy     (busy)
);

// File: tb/page_prog_ctrl_tb.sv
module page_prog_ctrl_tb;
  localparam int WIN = 16;
  localparam int PRG = 120;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0, wr_ready;
  logic [12:0]  wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic         rd_valid = 1'b0, rd_ready;
  logic [12:0]  rd_addr = '0;
  logic         rsp_valid, rsp_ready = 1'b1;
  logic [7:0]   rsp_data;
  logic [12:0]  arr_raddr;
  logic [7:0]   arr_rdata = 8'hFF;
  logic         cmt_valid, cmt_ready = 1'b1;
  logic [6:0]   cmt_page;
  logic [511:0] cmt_data;
  logic [63:0]  cmt_mask;
  logic         busy;

  page_prog_ctrl #(.WIN_CYCLES(WIN), .PROG_CYCLES(PRG)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_page(cmt_page),
    .cmt_data(cmt_data), .cmt_mask(cmt_mask), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural array attached to the commit port
  logic [7:0] amem [int];
  always @(posedge clk)
    if (rst_n && cmt_valid && cmt_ready)
      for (int i = 0; i < 64; i++)
        if (cmt_mask[i]) amem[int'(cmt_page) * 64 + i] = cmt_data[i*8 +: 8];
  always @(negedge clk) begin
    #1;
    arr_rdata = amem.exists(int'(arr_raddr)) ? amem[int'(arr_raddr)] : 8'hFF;
  end

  // Reference model: 0 idle, 1 loading, 2 programming, 3 commit pending
  int         m_state = 0, m_cnt = 0, m_pc = 0, m_page = 0;
  logic [7:0] m_last = '0;
  logic       m_tog = 1'b0, m_rsp_v = 1'b0;
  logic [7:0] m_rsp_d = '0;
  logic [7:0] m_pend [int];
  logic [7:0] refmem [int];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_rsp_v = 1'b0; m_tog = 1'b0;
    end else begin
      bit rrdy;
      rrdy = !m_rsp_v || rsp_ready;
      if (rd_valid && rrdy) begin
        m_rsp_v = 1'b1;
        if (m_state >= 2) begin
          m_rsp_d = {~m_last[7], m_tog, m_last[5:0]};
          m_tog = ~m_tog;
        end else begin
          m_rsp_d = refmem.exists(int'(rd_addr)) ? refmem[int'(rd_addr)] : 8'hFF;
        end
      end else if (rsp_ready) begin
        m_rsp_v = 1'b0;
      end
      case (m_state)
        0: if (wr_valid) begin
          m_page = int'(wr_addr[12:6]);
          m_pend.delete();
          m_pend[int'(wr_addr[5:0])] = wr_data;
          m_last = wr_data; m_cnt = 0; m_state = 1;
        end
        1: if (wr_valid && int'(wr_addr[12:6]) == m_page) begin
          m_pend[int'(wr_addr[5:0])] = wr_data;
          m_last = wr_data; m_cnt = 0;
        end else if (m_cnt == WIN - 1) begin
          m_state = 2; m_pc = 0; m_tog = 1'b0;
        end else begin
          m_cnt++;
        end
        2: if (m_pc == PRG - 1) m_state = 3; else m_pc++;
        default: if (cmt_ready) begin
          foreach (m_pend[k]) refmem[m_page * 64 + k] = m_pend[k];
          m_state = 0;
        end
      endcase
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(busy == (m_state != 0), "R1", "busy", busy, m_state != 0);
      check(wr_ready == (m_state < 2), "R10", "wr_ready", wr_ready, m_state < 2);
      check(cmt_valid == (m_state == 3), "R6", "cmt_valid", cmt_valid, m_state == 3);
      check(rsp_valid == m_rsp_v, "R11", "rsp_valid", rsp_valid, m_rsp_v);
      if (m_rsp_v)
        check(rsp_data == m_rsp_d, "R9", "rsp_data", rsp_data, m_rsp_d);
      if (cmt_valid && m_state == 3) begin
        check($countones(cmt_mask) == m_pend.num(), "R5", "mask bits",
              $countones(cmt_mask), m_pend.num());
        check(int'(cmt_page) == m_page, "R1", "cmt_page", cmt_page, m_page);
      end
    end
  end

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    do @(posedge clk); while (!wr_ready);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_get(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a;
    do @(posedge clk); while (!rd_ready);
    @(negedge clk);
    rd_valid = 1'b0;
    d = rsp_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(!busy && wr_ready && rd_ready && !cmt_valid && !rsp_valid, "R12",
          "reset outputs", {busy, wr_ready, rd_ready, cmt_valid, rsp_valid}, 5'b01100);

    // Page 5: out of order, repeated offset, foreign page in the middle
    wr(13'h143, 8'hA5);
    check(busy, "R1", "busy after first load", busy, 1);
    wr(13'h17C, 8'h3C);
    wr(13'h183, 8'h77);              // R3 foreign page
    wr(13'h143, 8'h81);              // R2 overwrite
    n = 0;
    while (wr_ready) begin @(negedge clk); n++; end
    check(n == WIN, "R4", "window length", n, WIN);
    rd_get(13'h143, d);
    check(d == 8'h01, "R7", "status read 1", d, 8'h01);
    rd_get(13'h000, d);
    check(d == 8'h41, "R8", "status read 2", d, 8'h41);
    rd_get(13'h143, d);
    check(d == 8'h01, "R8", "status read 3", d, 8'h01);
    check(!wr_ready, "R10", "wr_ready in program", wr_ready, 0);
    wr(13'h200, 8'h5A);              // R10 waits for commit
    wait_idle();
    rd_get(13'h143, d); check(d == 8'h81, "R2", "last value kept", d, 8'h81);
    rd_get(13'h17C, d); check(d == 8'h3C, "R2", "any order", d, 8'h3C);
    rd_get(13'h144, d); check(d == 8'hFF, "R5", "unloaded byte", d, 8'hFF);
    rd_get(13'h183, d); check(d == 8'hFF, "R3", "foreign byte dropped", d, 8'hFF);
    rd_get(13'h200, d); check(d == 8'h5A, "R10", "held load taken", d, 8'h5A);

    // Page 16: load on the last allowed edge joins
    wr(13'h400, 8'h11);
    idle(WIN - 2);
    wr(13'h401, 8'h22);
    check(wr_ready, "R4", "boundary load joins", wr_ready, 1);
    n = 0;
    while (wr_ready) begin @(negedge clk); n++; end
    check(n == WIN, "R4", "window after boundary", n, WIN);
    n = 0;
    while (busy) begin @(negedge clk); n++; end
    check(n == PRG + 1, "R5", "program length", n, PRG + 1);
    rd_get(13'h400, d); check(d == 8'h11, "R4", "first byte", d, 8'h11);
    rd_get(13'h401, d); check(d == 8'h22, "R4", "boundary byte", d, 8'h22);

    // Page 17: one cycle late is too late; commit back-pressure
    cmt_ready = 1'b0;
    wr(13'h440, 8'h33);
    idle(WIN);
    check(!wr_ready, "R4", "late load blocked", wr_ready, 0);
    while (!cmt_valid) @(negedge clk);
    idle(6);
    check(cmt_valid && busy, "R6", "commit held", {cmt_valid, busy}, 2'b11);
    cmt_ready = 1'b1;
    wait_idle();
    rd_get(13'h440, d); check(d == 8'h33, "R6", "commit landed", d, 8'h33);

    // R11: response back-pressure
    @(negedge clk);
    rsp_ready = 1'b0; rd_valid = 1'b1; rd_addr = 13'h440;
    @(negedge clk);
    rd_addr = 13'h400;
    check(rsp_valid && !rd_ready, "R11", "stall", {rsp_valid, rd_ready}, 2'b10);
    check(rsp_data == 8'h33, "R11", "held data", rsp_data, 8'h33);
    idle(3);
    check(rsp_data == 8'h33 && rsp_valid, "R11", "still held", rsp_data, 8'h33);
    rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check(rsp_data == 8'h11, "R11", "second response", rsp_data, 8'h11);

    // R9: reads during loading see the array, not the page buffer
    wr(13'h480, 8'h99);
    rd_get(13'h480, d); check(d == 8'hFF, "R9", "read while loading", d, 8'hFF);
    wait_idle();
    rd_get(13'h480, d); check(d == 8'h99, "R9", "read after commit", d, 8'h99);

    idle(4);
    summary();
    $finish;
  end
endmodule